// File: doc/BRIEF.md
# Strobe-Serial Memory Host Sequencer

This block sits on the host side of a memory that is reached through one bidirectional data bit and three active-low strobes: chip select, output enable and write enable. A client hands it a command: read a run of bytes starting at an address, load and commit a page of bytes, or wait for a pending commit to finish. The sequencer turns that command into a train of single-bit bus read and bus write cycles. Each read or write command opens with the framing pattern read, write-0, read. It then shifts out a 16-bit address frame. After that it either clocks data bits in or clocks data bits out. A write closes with the commit pattern read, write-1, read, followed by status polling.

Write bytes arrive on a valid/ready stream that the sequencer pulls, one byte at a time. Read bytes leave on a valid/ready stream. When the client withholds `rd_ready`, the sequencer holds the byte and issues no further bus cycles until the byte is taken. It holds `wr_ready` high until a write byte is supplied. The interface is fully static, so these stalls are harmless. The command port is also valid/ready: `cmd_ready` is high only while the sequencer is idle. Every bus cycle has the same shape: data setup, strobe low, data hold, then recovery. Each phase length comes from a parameter counted in system clocks.

Top module: `mps_seq`

## Requirements
- R1: In reset and right after it, `ce_n`, `oe_n` and `we_n` are high, `dq_oe` is low, `busy` is low and `cmd_ready` is high.
- R2: Every accepted read (op 0) or write (op 1) command first issues a bus read, then a bus write that drives 0, then a bus read.
- R3: The address is then sent as 16 bus write cycles, most significant bit first. The frame is the 9-bit address zero-extended, so the first 7 bits are 0.
- R4: A read command with length N issues 8 bus read cycles per byte and assembles each byte MSB first. It delivers N bytes on `rd_data` and sends no new address between bytes.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_data` stays unchanged and no bus cycle starts.
- R6: A write command with length N takes N bytes from the write stream. For each byte it issues 8 bus write cycles carrying the bits MSB first. It then issues read, write-1, read.
- R7: After the commit pattern, and for a poll command (op 2), the sequencer issues bus reads until one returns 1. It then pulses `done` with `err` low.
- R8: A command is rejected if it is a read or write with length 0, a write with length above 8, a write whose address offset within its 8-byte page plus its length exceeds 8, or op 3. A rejected command issues no bus cycle, and `done` and `err` pulse together.
- R9: If the poll limit (5 in the bench) of consecutive bus reads all return 0, polling stops and `done` pulses with `err` high.
- R10: The strobe stays low for at least T_WP clocks (default 6). Strobe falls are at least T_CYC clocks apart (default 60). The strobe stays high at least T_REC clocks between cycles (default 40).
- R11: WE and OE are never low together while CE is low. `dq_oe` is high only during write cycles, and only with `oe_n` high.
- R12: During a write cycle, data is driven at least T_DS clocks (default 6) before WE falls. It stays stable while WE is low and is held at least T_DH clocks (default 1) after WE rises.
- R13: A bus read samples `dq_i` T_ACC clocks (default 9) after the strobe falls, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken when valid |
| cmd_op | input | 2 | 0 read, 1 write, 2 poll, 3 reserved |
| cmd_addr | input | 9 | Start byte address |
| cmd_len | input | 8 | Byte count |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Sequencer waiting for next write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Client accepts read byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-clock pulse at command end |
| err | output | 1 | With done: command rejected or poll timed out |
| ce_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| dq_o | output | 1 | Data bit driven to the memory |
| dq_oe | output | 1 | Drive enable for dq_o |
| dq_i | input | 1 | Data bit returned by the memory |

## Verification
The assertions assume that `rd_ready` is an ordinary handshake input: the client may hold it low for any length of time. They also assume that `rst_n` is held low for several clocks before the first command. They place no constraint on `dq_i`, because the bus-cycle shape never depends on the value returned. The bench's memory model drives `dq_i` to the complement of the intended bit until the access delay has elapsed. It keeps every write byte arriving through the stream handshake and holds `rd_ready` low for long stretches on chosen bytes. It offers only op codes and lengths that the requirements define, including the rejected ones.

// File: rtl/mps_pkg.sv
package mps_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_POLL  = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic {
    CYC_RD = 1'b0,
    CYC_WR = 1'b1
  } cyc_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_LOW, PH_POST, PH_REC
  } phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_ADDR, S_RDB, S_RDO, S_WRF, S_WRB, S_START, S_POLL
  } st_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mps_bus_cycle.sv
// One single-bit bus cycle: setup, strobe low, hold, recovery.
module mps_bus_cycle
  import mps_pkg::*;
#(
  parameter int T_CYC = 60,
  parameter int T_WP  = 6,
  parameter int T_REC = 40,
  parameter int T_OES = 10,
  parameter int T_OEH = 10,
  parameter int T_DS  = 6,
  parameter int T_DH  = 1,
  parameter int T_ACC = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  cyc_e req_kind,
  input  logic req_bit,
  output logic ack,
  output logic rbit,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_o,
  output logic dq_oe,
  input  logic dq_i
);

  localparam int ACC_N   = imax(T_ACC, 1);
  localparam int PRE_N   = imax(imax(T_DS, T_OES), 1);
  localparam int WLOW_N  = imax(T_WP, 1);
  localparam int RLOW_N  = imax(WLOW_N, ACC_N);
  localparam int POST_N  = imax(imax(T_DH, T_OEH), 1);
  localparam int REC_N   = imax(imax(T_REC, 1), T_CYC - PRE_N - WLOW_N - POST_N);
  localparam int MAX_N   = imax(imax(PRE_N, RLOW_N), imax(POST_N, REC_N));
  localparam int CNT_W   = $clog2(MAX_N + 1);
  localparam int SAMP_AT = RLOW_N - ACC_N;

  phase_e           ph;
  cyc_e             kind;
  logic             wbit;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      kind <= CYC_RD;
      wbit <= 1'b0;
      cnt  <= '0;
      rbit <= 1'b1;
    end else begin
      case (ph)
        PH_IDLE: if (req) begin
          kind <= req_kind;
          wbit <= req_bit;
          cnt  <= CNT_W'(PRE_N - 1);
          ph   <= PH_PRE;
        end
        PH_PRE: if (cnt == '0) begin
          ph  <= PH_LOW;
          cnt <= (kind == CYC_WR) ? CNT_W'(WLOW_N - 1) : CNT_W'(RLOW_N - 1);
        end else cnt <= cnt - 1'b1;
        PH_LOW: begin
          if (kind == CYC_RD && cnt == CNT_W'(SAMP_AT)) rbit <= dq_i;
          if (cnt == '0) begin
            ph  <= PH_POST;
            cnt <= CNT_W'(POST_N - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_POST: if (cnt == '0) begin
          ph  <= PH_REC;
          cnt <= CNT_W'(REC_N - 1);
        end else cnt <= cnt - 1'b1;
        PH_REC: if (cnt == '0) ph <= PH_IDLE;
                else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ack   = (ph == PH_REC) && (cnt == '0);
    ce_n  = (ph != PH_LOW);
    we_n  = !((ph == PH_LOW) && (kind == CYC_WR));
    oe_n  = !((ph == PH_LOW) && (kind == CYC_RD));
    dq_oe = (kind == CYC_WR) && ((ph == PH_PRE) || (ph == PH_LOW) || (ph == PH_POST));
    dq_o  = wbit;
  end

endmodule

// File: rtl/mps_cmd_check.sv
// Decides up front whether a command may run.
module mps_cmd_check
  import mps_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PAGE  = 8
) (
  input  op_e                      op,
  input  logic [$clog2(PAGE)-1:0]  page_off,
  input  logic [LEN_W-1:0]         len,
  output logic                     reject
);

  localparam int PG_W = $clog2(PAGE);

  logic [LEN_W:0] span;
  logic           len_zero;
  logic           len_big;

  always_comb begin
    span     = {1'b0, len} + (LEN_W+1)'(page_off);
    len_zero = (len == '0);
    len_big  = ({1'b0, len} > (LEN_W+1)'(PAGE));
    case (op)
      OP_READ:  reject = len_zero;
      OP_WRITE: reject = len_zero || len_big || (span > (LEN_W+1)'(PAGE));
      OP_POLL:  reject = 1'b0;
      default:  reject = 1'b1;
    endcase
  end

  if (PG_W < 1) begin : g_bad_page
    initial $display("mps_cmd_check: PAGE must be at least 2");
  end

endmodule

// File: rtl/mps_seq.sv
module mps_seq
  import mps_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int FRAME_W    = 16,
  parameter int DATA_W     = 8,
  parameter int LEN_W      = 8,
  parameter int PAGE       = 8,
  parameter int POLL_LIMIT = 32768,
  parameter int T_CYC      = 60,
  parameter int T_WP       = 6,
  parameter int T_REC      = 40,
  parameter int T_OES      = 10,
  parameter int T_OEH      = 10,
  parameter int T_DS       = 6,
  parameter int T_DH       = 1,
  parameter int T_ACC      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              dq_o,
  output logic              dq_oe,
  input  logic              dq_i
);

  localparam int PG_W   = $clog2(PAGE);
  localparam int BIT_W  = $clog2(imax(FRAME_W, DATA_W) + 1);
  localparam int PCNT_W = $clog2(POLL_LIMIT + 1);

  st_e                st;
  op_e                op_in;
  op_e                op_q;
  logic [BIT_W-1:0]   cnt;
  logic [FRAME_W-1:0] ash;
  logic [DATA_W-1:0]  rsh;
  logic [DATA_W-1:0]  wsh;
  logic [LEN_W-1:0]   remain;
  logic [PCNT_W-1:0]  pcnt;
  logic               pend;
  logic               done_q;
  logic               err_q;
  logic               reject;

  logic               cyc_req;
  cyc_e               cyc_kind;
  logic               cyc_bit;
  logic               cyc_ack;
  logic               rbit;

  assign op_in = op_e'(cmd_op);

  mps_cmd_check #(.LEN_W(LEN_W), .PAGE(PAGE)) u_check (
    .op       (op_in),
    .page_off (cmd_addr[PG_W-1:0]),
    .len      (cmd_len),
    .reject   (reject)
  );

  mps_bus_cycle #(
    .T_CYC(T_CYC), .T_WP(T_WP), .T_REC(T_REC), .T_OES(T_OES),
    .T_OEH(T_OEH), .T_DS(T_DS), .T_DH(T_DH), .T_ACC(T_ACC)
  ) u_cycle (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (cyc_req),
    .req_kind (cyc_kind),
    .req_bit  (cyc_bit),
    .ack      (cyc_ack),
    .rbit     (rbit),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe),
    .dq_i     (dq_i)
  );

  // Which bus cycle the current state asks for.
  always_comb begin
    cyc_req  = 1'b0;
    cyc_kind = CYC_RD;
    cyc_bit  = 1'b0;
    case (st)
      S_RST: begin
        cyc_req = !pend;
        if (cnt == BIT_W'(1)) cyc_kind = CYC_WR;
      end
      S_ADDR: begin
        cyc_req  = !pend;
        cyc_kind = CYC_WR;
        cyc_bit  = ash[FRAME_W-1];
      end
      S_RDB:  cyc_req = !pend;
      S_WRB: begin
        cyc_req  = !pend;
        cyc_kind = CYC_WR;
        cyc_bit  = wsh[DATA_W-1];
      end
      S_START: begin
        cyc_req = !pend;
        if (cnt == BIT_W'(1)) begin
          cyc_kind = CYC_WR;
          cyc_bit  = 1'b1;
        end
      end
      S_POLL: cyc_req = !pend;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_READ;
      cnt    <= '0;
      ash    <= '0;
      rsh    <= '0;
      wsh    <= '0;
      remain <= '0;
      pcnt   <= '0;
      pend   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (cyc_req) pend <= 1'b1;
      if (cyc_ack) pend <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (reject) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            op_q   <= op_in;
            ash    <= FRAME_W'(cmd_addr);
            remain <= cmd_len;
            cnt    <= '0;
            pcnt   <= '0;
            st     <= (op_in == OP_POLL) ? S_POLL : S_RST;
          end
        end
        S_RST: if (cyc_ack) begin
          if (cnt == BIT_W'(2)) begin
            cnt <= '0;
            st  <= S_ADDR;
          end else cnt <= cnt + 1'b1;
        end
        S_ADDR: if (cyc_ack) begin
          ash <= ash << 1;
          if (cnt == BIT_W'(FRAME_W - 1)) begin
            cnt <= '0;
            st  <= (op_q == OP_READ) ? S_RDB : S_WRF;
          end else cnt <= cnt + 1'b1;
        end
        S_RDB: if (cyc_ack) begin
          rsh <= {rsh[DATA_W-2:0], rbit};
          if (cnt == BIT_W'(DATA_W - 1)) begin
            cnt <= '0;
            st  <= S_RDO;
          end else cnt <= cnt + 1'b1;
        end
        S_RDO: if (rd_ready) begin
          if (remain == LEN_W'(1)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            remain <= remain - 1'b1;
            st     <= S_RDB;
          end
        end
        S_WRF: if (wr_valid) begin
          wsh <= wr_data;
          cnt <= '0;
          st  <= S_WRB;
        end
        S_WRB: if (cyc_ack) begin
          wsh <= wsh << 1;
          if (cnt == BIT_W'(DATA_W - 1)) begin
            cnt <= '0;
            if (remain == LEN_W'(1)) st <= S_START;
            else begin
              remain <= remain - 1'b1;
              st     <= S_WRF;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_START: if (cyc_ack) begin
          if (cnt == BIT_W'(2)) begin
            cnt  <= '0;
            pcnt <= '0;
            st   <= S_POLL;
          end else cnt <= cnt + 1'b1;
        end
        S_POLL: if (cyc_ack) begin
          if (rbit) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else if (pcnt == PCNT_W'(POLL_LIMIT - 1)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else pcnt <= pcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready = (st == S_IDLE);
    busy      = (st != S_IDLE);
    wr_ready  = (st == S_WRF);
    rd_valid  = (st == S_RDO);
    rd_data   = rsh;
    done      = done_q;
    err       = err_q;
  end

endmodule

// File: rtl/mps_seq_chk.sv
module mps_seq_chk #(
  parameter int T_WP   = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_o,
  input logic              dq_oe,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              done,
  input logic              err
);

  logic [15:0] we_low_len;

  always_ff @(posedge clk) begin
    if (!rst_n) we_low_len <= '0;
    else if (!we_n) we_low_len <= (we_low_len == 16'hFFFF) ? we_low_len : we_low_len + 16'd1;
    else we_low_len <= '0;
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_n && !we_n && !oe_n));

  assert_drive_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  assert_data_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && $stable(dq_o)));

  assert_we_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_low_len >= 16'(T_WP)));

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_no_bus_while_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ce_n);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

endmodule

bind mps_seq mps_seq_chk #(.T_WP(T_WP), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .dq_o     (dq_o),
  .dq_oe    (dq_oe),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .done     (done),
  .err      (err)
);

// File: tb/test_mps_seq.sv
`timescale 1ns/1ps
module test_mps_seq;
  import mps_pkg::*;

  localparam int T_CYC    = 60;
  localparam int T_WP     = 6;
  localparam int T_REC    = 40;
  localparam int T_DS     = 6;
  localparam int T_DH     = 1;
  localparam int T_ACC    = 9;
  localparam int POLL_LIM = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [8:0] cmd_addr = '0;
  logic [7:0] cmd_len = '0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       busy, done, err;
  logic       ce_n, oe_n, we_n, dq_o, dq_oe;
  logic       dq_i = 1'b1;

  always #2.5 clk = ~clk;

  mps_seq #(.POLL_LIMIT(POLL_LIM)) i_mps_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  typedef struct {
    bit    wr;
    bit    b;
    string tag;
  } cyc_t;

  cyc_t       exp_q[$];
  logic [7:0] rd_exp_q[$];
  logic [7:0] wr_src_q[$];
  logic [7:0] mem_img [512];

  int checks = 0;
  int fails  = 0;
  int done_cnt = 0;
  bit last_err = 1'b0;
  int stall_len = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor / memory model / stream handlers, all at the falling edge.
  bit   ce_prev = 1'b1;
  bit   cur_valid = 1'b0;
  cyc_t cur;
  int   low_len = 0, high_len = 1000, since_fall = 0;
  bit   have_fall = 1'b0;
  bit   saw_we = 0, saw_oe = 0, bad_excl = 0, wdrv = 0, wsample = 0;
  int   rd_age = 0, pre_cnt = 0, post_cnt = 0;
  bit   in_post = 0, dq_oe_prev = 0;
  int   wait_ctr = 0;
  bit   wr_pop_pend = 0;
  bit   fell_in_out = 0;
  logic [7:0] out_hold = '0;
  bit   out_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since_fall++;
      // cycle start
      if (ce_prev && !ce_n) begin
        if (rd_valid) fell_in_out = 1;
        if (have_fall) chk(since_fall >= T_CYC, "R10", "strobe fall spacing", since_fall, T_CYC);
        chk(high_len >= T_REC, "R10", "strobe recovery", high_len, T_REC);
        have_fall = 1;
        since_fall = 0;
        low_len = 0;
        saw_we = 0; saw_oe = 0; bad_excl = 0; wdrv = 0;
        if (!we_n) chk(pre_cnt >= T_DS, "R12", "data setup", pre_cnt, T_DS);
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected bus cycle", 1, 0);
          cur_valid = 0;
        end else begin
          cur = exp_q[0];
          cur_valid = 1;
        end
      end
      if (!ce_n) begin
        low_len++;
        if (!we_n) begin saw_we = 1; wdrv = dq_oe; wsample = dq_o; end
        if (!oe_n) saw_oe = 1;
        if (!we_n && !oe_n) bad_excl = 1;
      end
      // R13: wrong value until access delay has elapsed
      if (!ce_n && !oe_n) rd_age++; else rd_age = 0;
      dq_i = (cur_valid && rd_age > 0) ? ((rd_age >= T_ACC) ? cur.b : ~cur.b) : 1'b1;
      // write setup / hold counters
      if (dq_oe && ce_n) begin
        if (in_post) post_cnt++; else pre_cnt++;
      end
      if (dq_oe_prev && !dq_oe) begin
        if (in_post) chk(post_cnt >= T_DH, "R12", "data hold", post_cnt, T_DH);
        in_post = 0; pre_cnt = 0; post_cnt = 0;
      end
      dq_oe_prev = dq_oe;
      // cycle end
      if (!ce_prev && ce_n) begin
        if (saw_we) in_post = 1;
        if (dq_oe) post_cnt = 1;
        chk(low_len >= T_WP, "R10", "strobe low width", low_len, T_WP);
        chk(!bad_excl, "R11", "WE and OE low together", bad_excl, 0);
        if (cur_valid) begin
          void'(exp_q.pop_front());
          chk(saw_we == cur.wr && saw_oe == !cur.wr, cur.tag, "cycle kind (1=write)", saw_we, cur.wr);
          if (cur.wr) chk(wdrv && wsample == cur.b, cur.tag, "written bit", wsample, cur.b);
          else chk(!wdrv, "R11", "drive during read", wdrv, 0);
        end
        cur_valid = 0;
        high_len = 0;
      end
      if (ce_n) high_len++;
      ce_prev = ce_n;

      // read stream with back-pressure
      if (rd_valid) begin
        if (!out_seen) begin out_seen = 1; out_hold = rd_data; end
        rd_ready = (wait_ctr >= stall_len);
        if (!rd_ready) wait_ctr++;
      end else rd_ready = 1'b0;
      if (rd_valid && rd_ready) begin
        chk(rd_data == out_hold, "R5", "byte held during stall", rd_data, out_hold);
        chk(!fell_in_out, "R5", "bus cycle during stall", fell_in_out, 0);
        if (rd_exp_q.size() == 0) chk(0, "R4", "unexpected read byte", rd_data, 0);
        else chk(rd_data == rd_exp_q.pop_front(), "R4/R13", "read byte", rd_data, 0);
        wait_ctr = 0; out_seen = 0; fell_in_out = 0;
      end

      // write stream source
      if (wr_pop_pend) void'(wr_src_q.pop_front());
      if (wr_src_q.size() > 0) begin wr_valid = 1'b1; wr_data = wr_src_q[0]; end
      else wr_valid = 1'b0;
      wr_pop_pend = wr_valid && wr_ready;

      if (done) begin done_cnt++; last_err = err; end
    end
  end

  task automatic push(input bit wr, input bit b, input string tag);
    cyc_t c;
    c.wr = wr; c.b = b; c.tag = tag;
    exp_q.push_back(c);
  endtask

  task automatic push_head(input logic [8:0] a);
    logic [15:0] fr;
    push(0, 1, "R2"); push(1, 0, "R2"); push(0, 1, "R2");
    fr = {7'b0, a};
    for (int i = 15; i >= 0; i--) push(1, fr[i], "R3");
  endtask

  task automatic run_cmd(input op_e op, input logic [8:0] a, input logic [7:0] n,
                         input bit exp_err, input string tag);
    int target;
    target = done_cnt + 1;
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_len = n; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait (done_cnt == target);
    @(negedge clk);
    chk(last_err == exp_err, tag, "error flag", last_err, exp_err);
    chk(exp_q.size() == 0, tag, "bus cycles left unissued", exp_q.size(), 0);
    chk(rd_exp_q.size() == 0 && wr_src_q.size() == 0, tag, "stream items left", rd_exp_q.size() + wr_src_q.size(), 0);
  endtask

  task automatic do_read(input logic [8:0] a, input int n, input int stall);
    logic [7:0] v;
    push_head(a);
    for (int k = 0; k < n; k++) begin
      v = mem_img[(a + k) % 512];
      for (int i = 7; i >= 0; i--) push(0, v[i], "R4");
      rd_exp_q.push_back(v);
    end
    stall_len = stall;
    run_cmd(OP_READ, a, 8'(n), 0, "R4");
  endtask

  task automatic do_write(input logic [8:0] a, input int n, input int busy_polls);
    logic [7:0] v;
    push_head(a);
    for (int k = 0; k < n; k++) begin
      v = 8'((k * 53 + a + 17) & 255);
      wr_src_q.push_back(v);
      for (int i = 7; i >= 0; i--) push(1, v[i], "R6");
    end
    push(0, 1, "R6"); push(1, 1, "R6"); push(0, 0, "R6");
    for (int p = 0; p < busy_polls; p++) push(0, 0, "R7");
    push(0, 1, "R7");
    run_cmd(OP_WRITE, a, 8'(n), 0, "R6");
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem_img[i] = 8'((i * 37 + 5) & 255);
    repeat (4) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1", "strobes in reset", {ce_n, oe_n, we_n}, 7);
    chk(!dq_oe && !busy && cmd_ready, "R1", "idle in reset", {dq_oe, busy, cmd_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && !busy && cmd_ready, "R1", "idle after reset", busy, 0);

    do_read(9'h1FE, 3, 150);   // wraps in the memory, no new address
    do_read(9'h043, 2, 0);
    do_write(9'h0A5, 3, 2);
    do_write(9'h100, 8, 0);

    run_cmd(OP_WRITE, 9'h010, 8'd0, 1, "R8");
    run_cmd(OP_WRITE, 9'h010, 8'd9, 1, "R8");
    run_cmd(OP_WRITE, 9'h0A6, 8'd3, 1, "R8");
    run_cmd(OP_READ,  9'h000, 8'd0, 1, "R8");
    run_cmd(OP_RSVD,  9'h000, 8'd1, 1, "R8");

    for (int p = 0; p < POLL_LIM; p++) push(0, 0, "R9");
    run_cmd(OP_POLL, 9'h000, 8'd0, 1, "R9");

    push(0, 0, "R7"); push(0, 1, "R7");
    run_cmd(OP_POLL, 9'h000, 8'd0, 0, "R7");

    repeat (20) @(negedge clk);
    chk(!busy && cmd_ready && ce_n, "R1", "idle at end", busy, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule